// File: doc/BRIEF.md
# Eight-Stage Pipeline Hazard Interlock

This block is the hazard and forwarding controller for an in-order integer pipeline of eight stages: two fetch stages, decode (D), execute (X), two data-read stages (DF, then DS), a tag-check stage (DC) and write-back (W). Each cycle it looks at the destination register, load flag and valid bit of every stage from X to W, the two source registers of the instruction sitting in D, and the tag comparison result produced in DC. From these it drives the operand-forwarding selects for the instruction in X, a freeze for the front stages, a bubble for X, a freeze for the whole pipeline and a one-cycle back-up request.

Load data is read over DF and DS and cannot be bypassed out of DF, so a consumer in D whose source matches a load in X or DF waits in D until that load has moved on to DS. That is a two-cycle penalty for a consumer right behind the load and one cycle for a consumer two slots behind. An ALU result can be bypassed from DF onward. When a load in DC fails its tag check, the block asks the datapath to back up one cycle and freezes everything until the refill engine reports completion. The outputs are plain level control signals with no handshake, because every signal is fresh each cycle and nothing is queued.

The two source registers of D are captured into an internal X-stage copy as the instruction advances, and the forwarding selects for the X operands are computed from that copy.

Top module: `pipe8_hazard_ctl`

## Requirements
- R1: Each X operand select shows the youngest valid stage whose destination equals that operand's source, with codes 1 = DF, 2 = DS, 3 = DC, 4 = W, and 0 = register file when no stage matches. Stage slots in `stg_valid`, `stg_dst` and `stg_load` are indexed 0 = X, 1 = DF, 2 = DS, 3 = DC, 4 = W. Each destination sits at bits [s*REG_W +: REG_W].
- R2: A source of register 0 never gets a forwarding select other than 0, even when a valid stage has destination 0.
- R3: When `d_valid` is high and either D source matches the destination of a valid load in X or DF, `stall_front` and `bubble_x` are both high in that same cycle.
- R4: A matching load in DS, DC or W, or a matching non-load in X or DF, causes no stall.
- R5: Register 0 sources never interlock, and an invalid D instruction never interlocks.
- R6: A cycle with a load interlock puts a bubble into the X-stage source copy, so in the next cycle both selects are 0 whatever the stage destinations are.
- R7: A valid load in DC with `dc_tag_hit` low, while the pipeline is not frozen, raises `backup_req` for exactly one cycle. In that same cycle `hold_all` and `stall_front` go high and `bubble_x` is low.
- R8: `hold_all` stays high from the miss cycle through the cycle in which `refill_done` is seen, and drops in the following cycle.
- R9: While `hold_all` is high, the X-stage source copy keeps its value. Changes on the D inputs during the freeze do not appear in the selects after it ends, and no bubble is inserted.
- R10: After reset, with no valid stages, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d_valid | input | 1 | D holds a real instruction |
| d_src_a | input | REG_W | First source register of the D instruction |
| d_src_b | input | REG_W | Second source register of the D instruction |
| stg_valid | input | 5 | Valid bit per stage, 0 = X to 4 = W |
| stg_dst | input | 5*REG_W | Destination register per stage, packed |
| stg_load | input | 4 | Load flag for X, DF, DS and DC |
| dc_tag_hit | input | 1 | Tag comparison result of the DC stage |
| refill_done | input | 1 | Refill for the missed load has finished |
| fwd_a_sel | output | 3 | Forwarding select, X operand A |
| fwd_b_sel | output | 3 | Forwarding select, X operand B |
| stall_front | output | 1 | Freeze IF, IS and D |
| bubble_x | output | 1 | Load an empty slot into X |
| backup_req | output | 1 | One-cycle request to back the pipeline up by one cycle |
| hold_all | output | 1 | Freeze every stage (miss handling) |

## Verification
The bench walks a table of single-producer cases that separates a load in DF from one in DS. A design that allows bypass from DF, or that keeps stalling once the load reaches DS, gives the wrong stall on one of those rows. Directed cases put several matching producers in flight to check youngest-first priority, and use register 0 as a destination to catch a design that forwards or stalls on it. They also check that the interlock empties X rather than holding it, which a design that repeats the consumer would get wrong. A tag-miss sequence changes the D sources during a long freeze, which catches a design that lets the X copy update while frozen. The same sequence also catches a back-up pulse that lasts more than one cycle and a hold that drops before or well after `refill_done`.

// File: rtl/pipe8_hz_pkg.sv
package pipe8_hz_pkg;
  // Stages tracked by the controller, oldest last: X, DF, DS, DC, W.
  localparam int NSTG      = 5;
  localparam int ST_X      = 0;
  localparam int ST_DF     = 1;
  localparam int ST_DS     = 2;
  localparam int ST_DC     = 3;
  localparam int ST_W      = 4;
  // Stages whose load data is not yet bypassable by a consumer leaving D.
  localparam int LU_STAGES = 2;
  // Stages that carry a load flag (X..DC).
  localparam int LD_STAGES = 4;

  // Select code equals the stage index it points at; 0 means register file.
  typedef enum logic [2:0] {
    FWD_RF = 3'd0,
    FWD_DF = 3'd1,
    FWD_DS = 3'd2,
    FWD_DC = 3'd3,
    FWD_W  = 3'd4
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_select.sv
module hz_fwd_select
  import pipe8_hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          src_valid,
  input  logic [REG_W-1:0]              src,
  input  logic [NSTG-2:0]               prod_valid, // DF..W
  input  logic [(NSTG-1)*REG_W-1:0]     prod_dst,   // DF..W
  output fwd_sel_e                      sel
);
  logic src_live;
  assign src_live = src_valid && (src != '0);

  // Walk from oldest (W) to youngest (DF); the last hit wins.
  always_comb begin
    sel = FWD_RF;
    for (int s = NSTG - 2; s >= 0; s--) begin
      if (src_live && prod_valid[s] && (prod_dst[s*REG_W +: REG_W] == src))
        sel = fwd_sel_e'(s + 1);
    end
  end

  // R2: register 0 is never bypassed
  assert_r0_no_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == FWD_RF));

  // R6: an empty X slot never selects a bypass path
  assert_bubble_no_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_valid) |-> (sel == FWD_RF));
endmodule

// File: rtl/hz_load_interlock.sv
module hz_load_interlock
  import pipe8_hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          d_valid,
  input  logic [REG_W-1:0]              src_a,
  input  logic [REG_W-1:0]              src_b,
  input  logic [LU_STAGES-1:0]          ld_valid, // X, DF
  input  logic [LU_STAGES*REG_W-1:0]    ld_dst,
  input  logic [LU_STAGES-1:0]          ld_flag,
  output logic                          load_stall
);
  logic [LU_STAGES-1:0] hit;

  for (genvar s = 0; s < LU_STAGES; s++) begin : g_lu
    logic [REG_W-1:0] dst;
    logic             pend;
    assign dst  = ld_dst[s*REG_W +: REG_W];
    assign pend = ld_valid[s] && ld_flag[s] && (dst != '0);
    assign hit[s] = pend && ((dst == src_a) || (dst == src_b));
  end

  assign load_stall = d_valid && (|hit);

  // R5: invalid D never interlocks
  assert_idle_d_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!d_valid) |-> !load_stall);

  // R5: register 0 sources never interlock
  assert_r0_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_a == '0) && (src_b == '0)) |-> !load_stall);
endmodule

// File: rtl/hz_miss_ctl.sv
module hz_miss_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic tag_miss,
  input  logic refill_done,
  output logic backup_req,
  output logic hold_all
);
  typedef enum logic {MC_RUN = 1'b0, MC_WAIT = 1'b1} mc_state_e;
  mc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MC_RUN:  if (tag_miss)    state_d = MC_WAIT;
      MC_WAIT: if (refill_done) state_d = MC_RUN;
      default: state_d = MC_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= MC_RUN;
    else        state_q <= state_d;
  end

  assign backup_req = (state_q == MC_RUN) && tag_miss;
  assign hold_all   = (state_q == MC_WAIT) || backup_req;

  // R7: back-up request is a single-cycle pulse
  assert_backup_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    backup_req |=> !backup_req);

  // R8: the freeze is still in force after the back-up cycle
  assert_hold_after_backup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    backup_req |=> hold_all);

  // R8: without refill completion the freeze persists
  assert_hold_until_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_all && !backup_req && !refill_done) |=> hold_all);
endmodule

// File: rtl/pipe8_hazard_ctl.sv
module pipe8_hazard_ctl
  import pipe8_hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    d_valid,
  input  logic [REG_W-1:0]        d_src_a,
  input  logic [REG_W-1:0]        d_src_b,
  input  logic [NSTG-1:0]         stg_valid,
  input  logic [NSTG*REG_W-1:0]   stg_dst,
  input  logic [LD_STAGES-1:0]    stg_load,
  input  logic                    dc_tag_hit,
  input  logic                    refill_done,
  output logic [2:0]              fwd_a_sel,
  output logic [2:0]              fwd_b_sel,
  output logic                    stall_front,
  output logic                    bubble_x,
  output logic                    backup_req,
  output logic                    hold_all
);
  localparam int NOPS = 2;

  logic load_stall;
  logic tag_miss;

  // Load-use interlock against X and DF.
  hz_load_interlock #(.REG_W(REG_W)) u_lu (
    .clk        (clk),
    .rst_n      (rst_n),
    .d_valid    (d_valid),
    .src_a      (d_src_a),
    .src_b      (d_src_b),
    .ld_valid   (stg_valid[LU_STAGES-1:0]),
    .ld_dst     (stg_dst[LU_STAGES*REG_W-1:0]),
    .ld_flag    (stg_load[LU_STAGES-1:0]),
    .load_stall (load_stall)
  );

  // Tag-miss back-up and refill wait.
  assign tag_miss = stg_valid[ST_DC] && stg_load[ST_DC] && !dc_tag_hit;

  hz_miss_ctl u_miss (
    .clk         (clk),
    .rst_n       (rst_n),
    .tag_miss    (tag_miss),
    .refill_done (refill_done),
    .backup_req  (backup_req),
    .hold_all    (hold_all)
  );

  assign stall_front = load_stall || hold_all;
  assign bubble_x    = load_stall && !hold_all;

  // X-stage copy of the D sources.
  logic [REG_W-1:0] d_src   [NOPS];
  logic [REG_W-1:0] x_src_q [NOPS];
  logic             x_vld_q;
  fwd_sel_e         sel     [NOPS];

  assign d_src[0] = d_src_a;
  assign d_src[1] = d_src_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_vld_q <= 1'b0;
      for (int i = 0; i < NOPS; i++) x_src_q[i] <= '0;
    end else if (!hold_all) begin
      x_vld_q <= d_valid && !load_stall;
      for (int i = 0; i < NOPS; i++) x_src_q[i] <= d_src[i];
    end
  end

  for (genvar op = 0; op < NOPS; op++) begin : g_op
    hz_fwd_select #(.REG_W(REG_W)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_valid  (x_vld_q),
      .src        (x_src_q[op]),
      .prod_valid (stg_valid[NSTG-1:1]),
      .prod_dst   (stg_dst[NSTG*REG_W-1:REG_W]),
      .sel        (sel[op])
    );
  end

  assign fwd_a_sel = sel[0];
  assign fwd_b_sel = sel[1];

  // R3: a bubble is only inserted while the front is frozen
  assert_bubble_implies_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_x |-> stall_front);

  // R9: no bubble while the whole pipe is frozen
  assert_no_bubble_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_all |-> (stall_front && !bubble_x));

  // R9: a frozen cycle leaves the X copy unchanged
  assert_xcopy_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_all |=> ($stable(x_src_q[0]) && $stable(x_src_q[1]) && $stable(x_vld_q)));
endmodule

// File: tb/pipe8_hazard_ctl_test.sv
module pipe8_hazard_ctl_test;
  localparam int RW = 5;
  localparam int NS = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            d_valid;
  logic [RW-1:0]   d_src_a, d_src_b;
  logic [NS-1:0]   stg_valid;
  logic [NS*RW-1:0] stg_dst;
  logic [3:0]      stg_load;
  logic            dc_tag_hit, refill_done;
  logic [2:0]      fwd_a_sel, fwd_b_sel;
  logic            stall_front, bubble_x, backup_req, hold_all;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pipe8_hazard_ctl #(.REG_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .d_valid(d_valid), .d_src_a(d_src_a), .d_src_b(d_src_b),
    .stg_valid(stg_valid), .stg_dst(stg_dst), .stg_load(stg_load),
    .dc_tag_hit(dc_tag_hit), .refill_done(refill_done),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .stall_front(stall_front),
    .bubble_x(bubble_x), .backup_req(backup_req), .hold_all(hold_all)
  );

  // Interlock vectors: {req, rs1, rs2, stage, rd, is_load, expect_stall}
  localparam int NV = 11;
  localparam logic [23:0] VEC [NV] = '{
    {4'd3, 5'd1,  5'd2,  3'd0, 5'd1,  1'b1, 1'b1},
    {4'd3, 5'd3,  5'd9,  3'd0, 5'd9,  1'b1, 1'b1},
    {4'd3, 5'd4,  5'd5,  3'd1, 5'd4,  1'b1, 1'b1},
    {4'd4, 5'd4,  5'd5,  3'd2, 5'd4,  1'b1, 1'b0},
    {4'd4, 5'd4,  5'd5,  3'd3, 5'd5,  1'b1, 1'b0},
    {4'd4, 5'd4,  5'd5,  3'd4, 5'd4,  1'b0, 1'b0},
    {4'd4, 5'd6,  5'd7,  3'd0, 5'd6,  1'b0, 1'b0},
    {4'd4, 5'd6,  5'd7,  3'd1, 5'd7,  1'b0, 1'b0},
    {4'd5, 5'd0,  5'd0,  3'd0, 5'd0,  1'b1, 1'b0},
    {4'd5, 5'd0,  5'd11, 3'd1, 5'd0,  1'b1, 1'b0},
    {4'd3, 5'd8,  5'd3,  3'd1, 5'd3,  1'b1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    d_valid = 1'b0; d_src_a = '0; d_src_b = '0;
    stg_valid = '0; stg_dst = '0; stg_load = '0;
    dc_tag_hit = 1'b1; refill_done = 1'b0;
  endtask

  task automatic set_stage(input int s, input logic [RW-1:0] rd, input logic ld);
    stg_valid[s] = 1'b1;
    stg_dst[s*RW +: RW] = rd;
    if (s < 4) stg_load[s] = ld;
  endtask

  task automatic next_cycle();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clear_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: reset state
    chk("R10", {fwd_a_sel, fwd_b_sel, stall_front, bubble_x, backup_req, hold_all}, 0,
        "outputs after reset");

    // Table walk: R3, R4, R5
    for (int v = 0; v < NV; v++) begin
      next_cycle();
      clear_all();
      d_valid = 1'b1;
      d_src_a = VEC[v][19:15];
      d_src_b = VEC[v][14:10];
      set_stage(int'(VEC[v][9:7]), VEC[v][6:2], VEC[v][1]);
      #1;
      chk($sformatf("R%0d", VEC[v][23:20]), {stall_front, bubble_x},
          VEC[v][0] ? 3 : 0, $sformatf("vector %0d stall/bubble", v));
    end

    // R5: invalid D with a hazard-shaped load does not stall
    next_cycle(); clear_all();
    d_src_a = 5'd12; set_stage(0, 5'd12, 1'b1);
    #1; chk("R5", stall_front, 0, "invalid D stall");

    // R1: youngest matching producer wins
    next_cycle(); clear_all();
    d_valid = 1'b1; d_src_a = 5'd5; d_src_b = 5'd6;
    next_cycle(); clear_all();
    set_stage(1, 5'd5, 1'b0); set_stage(2, 5'd5, 1'b0);
    set_stage(3, 5'd7, 1'b1); set_stage(4, 5'd6, 1'b0);
    #1;
    chk("R1", fwd_a_sel, 1, "operand A youngest DF");
    chk("R1", fwd_b_sel, 4, "operand B from W");

    next_cycle(); clear_all();
    d_valid = 1'b1; d_src_a = 5'd5; d_src_b = 5'd6;
    next_cycle(); clear_all();
    set_stage(3, 5'd5, 1'b1); set_stage(2, 5'd6, 1'b1); set_stage(4, 5'd6, 1'b0);
    #1;
    chk("R1", fwd_a_sel, 3, "operand A from DC");
    chk("R1", fwd_b_sel, 2, "operand B DS over W");

    // R2: register 0 never forwarded
    next_cycle(); clear_all();
    d_valid = 1'b1; d_src_a = 5'd0; d_src_b = 5'd0;
    next_cycle(); clear_all();
    set_stage(1, 5'd0, 1'b0); set_stage(4, 5'd0, 1'b0);
    #1;
    chk("R2", {fwd_a_sel, fwd_b_sel}, 0, "register 0 selects");

    // R6: interlock empties X
    next_cycle(); clear_all();
    d_valid = 1'b1; d_src_a = 5'd5; d_src_b = 5'd5;
    next_cycle(); clear_all();
    d_valid = 1'b1; d_src_a = 5'd5; d_src_b = 5'd5;
    set_stage(0, 5'd5, 1'b1);
    #1; chk("R6", bubble_x, 1, "bubble on load hazard");
    next_cycle(); clear_all();
    set_stage(1, 5'd5, 1'b0);
    #1; chk("R6", fwd_a_sel, 0, "X empty after bubble");

    // R7, R8, R9: tag miss, freeze, refill
    next_cycle(); clear_all();
    d_valid = 1'b1; d_src_a = 5'd5; d_src_b = 5'd6;
    next_cycle(); clear_all();
    d_valid = 1'b1; d_src_a = 5'd9; d_src_b = 5'd9;
    set_stage(0, 5'd9, 1'b1);
    set_stage(3, 5'd20, 1'b1); dc_tag_hit = 1'b0;
    #1;
    chk("R7", backup_req, 1, "back-up on miss");
    chk("R7", {hold_all, stall_front, bubble_x}, 6, "hold/stall/bubble on miss");
    next_cycle();
    #1;
    chk("R7", backup_req, 0, "back-up pulse ends");
    chk("R8", hold_all, 1, "hold after back-up");
    for (int k = 0; k < 20; k++) begin
      next_cycle();
      d_src_a = 5'(k + 10); d_src_b = 5'(k + 11);
    end
    #1;
    chk("R8", hold_all, 1, "hold during refill");
    chk("R9", bubble_x, 0, "no bubble during hold");
    next_cycle();
    refill_done = 1'b1;
    #1;
    chk("R8", hold_all, 1, "hold in refill_done cycle");
    next_cycle(); clear_all();
    set_stage(1, 5'd5, 1'b0); set_stage(2, 5'd6, 1'b0);
    #1;
    chk("R8", hold_all, 0, "hold released after refill");
    chk("R9", fwd_a_sel, 1, "X copy kept operand A");
    chk("R9", fwd_b_sel, 2, "X copy kept operand B");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule